// File: doc/BRIEF.md
# Shift, Rotate and Flag-Bit Unit

This block is the single-cycle bit-manipulation slice of an 8-bit processor datapath. Each cycle it takes an operand byte, a 3-bit bit index, the current status byte and an operation code. One clock edge later it presents a result byte and an updated status byte, both registered.

It covers four kinds of operation:
- logical shifts in both directions;
- rotates through the carry flag, and an arithmetic right shift;
- a nibble exchange;
- single-bit moves between a register bit and the T status flag, and forcing any status bit high or low by its index.

The status byte layout, from bit 7 down to bit 0, is I, T, H, S, V, N, Z, C. The operation codes are:

| Code | Operation |
|---|---|
| 0 | pass |
| 1 | shift left |
| 2 | shift right |
| 3 | rotate left |
| 4 | rotate right |
| 5 | arithmetic shift right |
| 6 | nibble swap |
| 7 | bit store |
| 8 | bit load |
| 9 | flag set |
| 10 | flag clear |
| 11 to 15 | pass |

Top module: `bsu_top`

## Requirements
- R1: While `rst` is high at a rising clock edge, `result_out` and `status_out` become 0x00 after that edge.
- R2: Code 1 (shift left) gives a result of operand bits 6..0 followed by a 0 in bit 0. It sets C to old bit 7 and H to old bit 3.
- R3: Code 2 (shift right) gives a result of a 0 in bit 7 followed by operand bits 7..1. It sets C to old bit 0 and leaves H unchanged.
- R4: Code 3 (rotate left) gives {operand[6:0], C_in}, with C set to old bit 7 and H to old bit 3. Code 4 (rotate right) gives {C_in, operand[7:1]}, with C set to old bit 0 and H unchanged. C_in is `status_in` bit 0.
- R5: Code 5 (arithmetic right shift) gives {operand[7], operand[7:1]}, with C set to old bit 0 and H unchanged.
- R6: Code 6 (nibble swap) gives {operand[3:0], operand[7:4]}, and `status_out` equals `status_in`.
- R7: Code 7 (bit store) copies operand bit `bit_idx` into T (status bit 6). All other status bits are unchanged and the result equals the operand. Code 8 (bit load) writes T into result bit `bit_idx`, keeps the other operand bits, and leaves the status unchanged.
- R8: For codes 1 to 5, Z is 1 exactly when the result is 0x00 and N is result bit 7. V equals N XOR C, S equals N XOR V, and I and T (bits 7 and 6) are unchanged.
- R9: Code 9 sets status bit `bit_idx` to 1 and code 10 clears it. The other status bits are unchanged and the result equals the operand.
- R10: Codes 0 and 11 to 15 give `result_out` equal to the operand and `status_out` equal to `status_in`.
- R11: Each output pair reflects the inputs present at the preceding rising edge. Operations issued on consecutive cycles each produce their own result one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| op_sel | input | 4 | Operation code |
| operand | input | 8 | Operand byte |
| bit_idx | input | 3 | Bit index for bit store/load and flag set/clear |
| status_in | input | 8 | Current status byte (I,T,H,S,V,N,Z,C from bit 7 down) |
| result_out | output | 8 | Registered result byte |
| status_out | output | 8 | Registered updated status byte |

## Verification
Both the result byte and the status byte are due exactly one rising edge after the inputs are presented, because the only storage on the path is the output register. The bench changes inputs on the falling edge and samples both outputs 2 ns after the next rising edge. Each expected pair is therefore tied to the operation issued half a cycle earlier. Issuing a different operation every cycle also shows that no result lingers into the next one or lags by an extra cycle.

// File: rtl/bsu_pkg.sv
package bsu_pkg;

  localparam int DATA_W = 8;
  localparam int STAT_W = 8;
  localparam int OP_W   = 4;

  // status bit positions
  localparam int FLAG_C = 0;
  localparam int FLAG_Z = 1;
  localparam int FLAG_N = 2;
  localparam int FLAG_V = 3;
  localparam int FLAG_S = 4;
  localparam int FLAG_H = 5;
  localparam int FLAG_T = 6;
  localparam int FLAG_I = 7;

  typedef enum logic [OP_W-1:0] {
    OP_PASS  = 4'd0,
    OP_SHL   = 4'd1,
    OP_SHR   = 4'd2,
    OP_ROTL  = 4'd3,
    OP_ROTR  = 4'd4,
    OP_ASHR  = 4'd5,
    OP_SWAP  = 4'd6,
    OP_TSTO  = 4'd7,
    OP_TLOD  = 4'd8,
    OP_FSET  = 4'd9,
    OP_FCLR  = 4'd10
  } bsu_op_e;

endpackage

// File: rtl/bsu_shifter.sv
module bsu_shifter
  import bsu_pkg::*;
#(
  parameter int W = DATA_W
) (
  input  bsu_op_e        op,
  input  logic [W-1:0]   din,
  input  logic           cin,
  output logic [W-1:0]   dout,
  output logic           cout,
  output logic           h_upd,
  output logic           h_val
);

  localparam int HALF = W / 2;

  always_comb begin
    dout  = din;
    cout  = cin;
    h_upd = 1'b0;
    h_val = din[HALF-1];
    case (op)
      OP_SHL: begin
        dout  = {din[W-2:0], 1'b0};
        cout  = din[W-1];
        h_upd = 1'b1;
      end
      OP_SHR: begin
        dout = {1'b0, din[W-1:1]};
        cout = din[0];
      end
      OP_ROTL: begin
        dout  = {din[W-2:0], cin};
        cout  = din[W-1];
        h_upd = 1'b1;
      end
      OP_ROTR: begin
        dout = {cin, din[W-1:1]};
        cout = din[0];
      end
      OP_ASHR: begin
        dout = {din[W-1], din[W-1:1]};
        cout = din[0];
      end
      OP_SWAP: begin
        dout = {din[HALF-1:0], din[W-1:HALF]};
      end
      default: begin
        dout = din;
      end
    endcase
  end

endmodule

// File: rtl/bsu_flagcalc.sv
module bsu_flagcalc
  import bsu_pkg::*;
#(
  parameter int W  = DATA_W,
  parameter int SW = STAT_W
) (
  input  logic [W-1:0]  res,
  input  logic          cout,
  input  logic          h_upd,
  input  logic          h_val,
  input  logic [SW-1:0] st_in,
  output logic [SW-1:0] st_out
);

  logic flag_n;
  logic flag_v;

  assign flag_n = res[W-1];
  assign flag_v = flag_n ^ cout;

  always_comb begin
    st_out          = st_in;
    st_out[FLAG_C]  = cout;
    st_out[FLAG_Z]  = (res == '0);
    st_out[FLAG_N]  = flag_n;
    st_out[FLAG_V]  = flag_v;
    st_out[FLAG_S]  = flag_n ^ flag_v;
    if (h_upd) begin
      st_out[FLAG_H] = h_val;
    end
  end

endmodule

// File: rtl/bsu_bitxfer.sv
module bsu_bitxfer
  import bsu_pkg::*;
#(
  parameter int W  = DATA_W,
  parameter int SW = STAT_W,
  localparam int IDX_W = $clog2(W)
) (
  input  bsu_op_e         op,
  input  logic [W-1:0]    din,
  input  logic [IDX_W-1:0] idx,
  input  logic [SW-1:0]   st_in,
  output logic [W-1:0]    dout,
  output logic [SW-1:0]   st_out
);

  logic [W-1:0] sel_onehot;
  logic         picked_bit;

  // one lane per data bit: decode and optional overwrite by T
  for (genvar g = 0; g < W; g++) begin : g_data_lane
    assign sel_onehot[g] = (idx == IDX_W'(g));
    assign dout[g] = (op == OP_TLOD && sel_onehot[g]) ? st_in[FLAG_T] : din[g];
  end

  assign picked_bit = |(din & sel_onehot);

  // one lane per status bit
  for (genvar g = 0; g < SW; g++) begin : g_stat_lane
    logic hit;
    assign hit = (idx == IDX_W'(g));
    always_comb begin
      st_out[g] = st_in[g];
      if (op == OP_FSET && hit) begin
        st_out[g] = 1'b1;
      end else if (op == OP_FCLR && hit) begin
        st_out[g] = 1'b0;
      end else if (op == OP_TSTO && g == FLAG_T) begin
        st_out[g] = picked_bit;
      end
    end
  end

endmodule

// File: rtl/bsu_top.sv
module bsu_top
  import bsu_pkg::*;
#(
  parameter int W  = DATA_W,
  parameter int SW = STAT_W,
  localparam int IDX_W = $clog2(W)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [OP_W-1:0]  op_sel,
  input  logic [W-1:0]     operand,
  input  logic [IDX_W-1:0] bit_idx,
  input  logic [SW-1:0]    status_in,
  output logic [W-1:0]     result_out,
  output logic [SW-1:0]    status_out
);

  bsu_op_e       op;
  logic [W-1:0]  sh_res;
  logic          sh_c;
  logic          sh_hupd;
  logic          sh_hval;
  logic [SW-1:0] sh_st;
  logic [W-1:0]  bx_res;
  logic [SW-1:0] bx_st;
  logic [W-1:0]  nxt_res;
  logic [SW-1:0] nxt_st;
  logic          is_shift;
  logic          is_bitop;

  assign op = bsu_op_e'(op_sel);

  bsu_shifter #(.W(W)) i_shifter (
    .op    (op),
    .din   (operand),
    .cin   (status_in[FLAG_C]),
    .dout  (sh_res),
    .cout  (sh_c),
    .h_upd (sh_hupd),
    .h_val (sh_hval)
  );

  bsu_flagcalc #(.W(W), .SW(SW)) i_flagcalc (
    .res    (sh_res),
    .cout   (sh_c),
    .h_upd  (sh_hupd),
    .h_val  (sh_hval),
    .st_in  (status_in),
    .st_out (sh_st)
  );

  bsu_bitxfer #(.W(W), .SW(SW)) i_bitxfer (
    .op     (op),
    .din    (operand),
    .idx    (bit_idx),
    .st_in  (status_in),
    .dout   (bx_res),
    .st_out (bx_st)
  );

  assign is_shift = (op_sel >= OP_W'(OP_SHL)) && (op_sel <= OP_W'(OP_ASHR));
  assign is_bitop = (op_sel >= OP_W'(OP_TSTO)) && (op_sel <= OP_W'(OP_FCLR));

  always_comb begin
    if (is_shift) begin
      nxt_res = sh_res;
      nxt_st  = sh_st;
    end else if (op_sel == OP_W'(OP_SWAP)) begin
      nxt_res = sh_res;
      nxt_st  = status_in;
    end else if (is_bitop) begin
      nxt_res = bx_res;
      nxt_st  = bx_st;
    end else begin
      nxt_res = operand;
      nxt_st  = status_in;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      result_out <= '0;
      status_out <= '0;
    end else begin
      result_out <= nxt_res;
      status_out <= nxt_st;
    end
  end

  AST_SHIFT_V_RULE: assert property (@(posedge clk) disable iff (rst)
    is_shift |=> (status_out[FLAG_V] == (status_out[FLAG_N] ^ status_out[FLAG_C]))); // R8

  AST_SHIFT_ZERO: assert property (@(posedge clk) disable iff (rst)
    is_shift |=> (status_out[FLAG_Z] == (result_out == '0))); // R8

  AST_SHIFT_IT_KEPT: assert property (@(posedge clk) disable iff (rst)
    is_shift |=> (status_out[FLAG_I:FLAG_T] == $past(status_in[FLAG_I:FLAG_T]))); // R8

  AST_SHR_MSB_ZERO: assert property (@(posedge clk) disable iff (rst)
    (op_sel == OP_W'(OP_SHR)) |=> (result_out[W-1] == 1'b0)); // R3

  AST_SWAP_FLAGS: assert property (@(posedge clk) disable iff (rst)
    (op_sel == OP_W'(OP_SWAP)) |=> (status_out == $past(status_in))); // R6

  AST_TLOD_FLAGS: assert property (@(posedge clk) disable iff (rst)
    (op_sel == OP_W'(OP_TLOD)) |=> (status_out == $past(status_in))); // R7

  AST_FSET_HIT: assert property (@(posedge clk) disable iff (rst)
    (op_sel == OP_W'(OP_FSET)) |=> (status_out[$past(bit_idx)] == 1'b1)); // R9

  AST_FCLR_HIT: assert property (@(posedge clk) disable iff (rst)
    (op_sel == OP_W'(OP_FCLR)) |=> (status_out[$past(bit_idx)] == 1'b0)); // R9

  AST_PASS_RESULT: assert property (@(posedge clk) disable iff (rst)
    (op_sel == OP_W'(OP_PASS)) |=> (result_out == $past(operand))); // R10

endmodule

// File: tb/test_bsu_top.sv
`timescale 1ns/1ps
module test_bsu_top;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] op_sel = 4'd0;
  logic [7:0] operand = 8'd0;
  logic [2:0] bit_idx = 3'd0;
  logic [7:0] status_in = 8'd0;
  logic [7:0] result_out;
  logic [7:0] status_out;

  int n_checks = 0;
  int n_fail   = 0;
  bit reported = 0;
  logic [31:0] lcg = 32'h1234_5678;

  always #4 clk = ~clk;

  bsu_top i_bsu_top (
    .clk        (clk),
    .rst        (rst),
    .op_sel     (op_sel),
    .operand    (operand),
    .bit_idx    (bit_idx),
    .status_in  (status_in),
    .result_out (result_out),
    .status_out (status_out)
  );

  function automatic logic [7:0] next_rand();
    lcg = lcg * 32'd1103515245 + 32'd12345;
    return lcg[23:16];
  endfunction

  // expected values written from the requirements
  function automatic void expect_of(input logic [3:0] op, input logic [7:0] d,
                                    input logic [2:0] idx, input logic [7:0] st,
                                    output logic [7:0] r, output logic [7:0] s);
    logic c;
    logic n;
    logic v;
    r = d;
    s = st;
    c = st[0];
    case (op)
      4'd1: begin r = {d[6:0], 1'b0}; c = d[7]; s[5] = d[3]; end
      4'd2: begin r = {1'b0, d[7:1]}; c = d[0]; end
      4'd3: begin r = {d[6:0], st[0]}; c = d[7]; s[5] = d[3]; end
      4'd4: begin r = {st[0], d[7:1]}; c = d[0]; end
      4'd5: begin r = {d[7], d[7:1]}; c = d[0]; end
      4'd6: r = {d[3:0], d[7:4]};
      4'd7: s[6] = d[idx];
      4'd8: r[idx] = st[6];
      4'd9: s[idx] = 1'b1;
      4'd10: s[idx] = 1'b0;
      default: ;
    endcase
    if (op >= 4'd1 && op <= 4'd5) begin
      n = r[7];
      v = n ^ c;
      s[0] = c;
      s[1] = (r == 8'h00);
      s[2] = n;
      s[3] = v;
      s[4] = n ^ v;
    end
  endfunction

  task automatic check(input string tag, input logic [7:0] er, input logic [7:0] es);
    n_checks++;
    if (result_out !== er || status_out !== es) begin
      n_fail++;
      $display("FAIL %s: result=%02h status=%02h expected result=%02h status=%02h",
               tag, result_out, status_out, er, es);
    end
  endtask

  // drive on falling edge, sample 2 ns after the next rising edge (R11)
  task automatic apply(input string tag, input logic [3:0] op, input logic [7:0] d,
                       input logic [2:0] idx, input logic [7:0] st);
    logic [7:0] er;
    logic [7:0] es;
    @(negedge clk);
    op_sel = op; operand = d; bit_idx = idx; status_in = st;
    expect_of(op, d, idx, st, er, es);
    @(posedge clk);
    #2;
    check(tag, er, es);
  endtask

  task automatic t_reset();
    @(negedge clk);
    rst = 1'b1; op_sel = 4'd0; operand = 8'hA5; status_in = 8'hFF;
    @(posedge clk); #2;
    check("R1 reset", 8'h00, 8'h00);
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic t_shl();
    apply("R2 shift-left 80", 4'd1, 8'h80, 3'd0, 8'h00);
    n_checks++;
    if (status_out !== 8'h1B) begin
      n_fail++;
      $display("FAIL R2 literal status=%02h expected=1b", status_out);
    end
    apply("R2 shift-left 08 H", 4'd1, 8'h08, 3'd0, 8'hC0);
    for (int i = 0; i < 40; i++) begin
      apply("R2 shift-left sweep", 4'd1, next_rand(), 3'd0, next_rand());
    end
  endtask

  task automatic t_shr();
    apply("R3 shift-right 01", 4'd2, 8'h01, 3'd0, 8'h20);
    for (int i = 0; i < 40; i++) begin
      apply("R3 shift-right sweep", 4'd2, next_rand(), 3'd0, next_rand());
    end
  endtask

  task automatic t_rotate();
    apply("R4 rotate-right C in", 4'd4, 8'h01, 3'd0, 8'h01);
    n_checks++;
    if (result_out !== 8'h80 || status_out !== 8'h15) begin
      n_fail++;
      $display("FAIL R4 literal result=%02h status=%02h expected=80 15", result_out, status_out);
    end
    apply("R4 rotate-left C in", 4'd3, 8'h7F, 3'd0, 8'h01);
    for (int i = 0; i < 40; i++) begin
      apply("R4 rotate-left sweep", 4'd3, next_rand(), 3'd0, next_rand());
      apply("R4 rotate-right sweep", 4'd4, next_rand(), 3'd0, next_rand());
    end
  endtask

  task automatic t_ashr();
    apply("R5 arith-right neg", 4'd5, 8'h81, 3'd0, 8'h00);
    apply("R5 arith-right pos", 4'd5, 8'h7E, 3'd0, 8'hFF);
    for (int i = 0; i < 40; i++) begin
      apply("R5 arith-right sweep", 4'd5, next_rand(), 3'd0, next_rand());
    end
  endtask

  task automatic t_shift_flags();
    // R8: zero result, negative result, I/T kept
    apply("R8 zero result", 4'd2, 8'h01, 3'd0, 8'hC0);
    apply("R8 negative result", 4'd4, 8'h00, 3'd0, 8'h01);
    apply("R8 flags all set in", 4'd1, 8'h40, 3'd0, 8'hFF);
  endtask

  task automatic t_swap();
    apply("R6 swap", 4'd6, 8'h3C, 3'd0, 8'h5A);
    for (int i = 0; i < 20; i++) begin
      apply("R6 swap sweep", 4'd6, next_rand(), 3'd0, next_rand());
    end
  endtask

  task automatic t_bitxfer();
    for (int b = 0; b < 8; b++) begin
      apply("R7 store bit set", 4'd7, 8'h01 << b, 3'(b), 8'h00);
      apply("R7 store bit clear", 4'd7, ~(8'h01 << b), 3'(b), 8'hFF);
      apply("R7 load T=1", 4'd8, 8'h00, 3'(b), 8'h40);
      apply("R7 load T=0", 4'd8, 8'hFF, 3'(b), 8'hBF);
    end
  endtask

  task automatic t_flagop();
    for (int b = 0; b < 8; b++) begin
      apply("R9 flag set", 4'd9, 8'h96, 3'(b), 8'h00);
      apply("R9 flag clear", 4'd10, 8'h69, 3'(b), 8'hFF);
    end
  endtask

  task automatic t_pass();
    apply("R10 code 0", 4'd0, 8'hC3, 3'd5, 8'h7E);
    for (int c = 11; c < 16; c++) begin
      apply("R10 unused code", 4'(c), next_rand(), 3'd2, next_rand());
    end
  endtask

  task automatic t_back_to_back();
    // R11: a different op every cycle, each checked one cycle later
    for (int i = 0; i < 60; i++) begin
      apply("R11 back-to-back", 4'(i % 11), next_rand(), 3'(i % 8), next_rand());
    end
  endtask

  task automatic report();
    if (!reported) begin
      reported = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    end
  endtask

  initial begin
    #(8 * 200000);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog expired");
    report();
    $finish;
  end

  initial begin
    t_reset();
    t_shl();
    t_shr();
    t_rotate();
    t_ashr();
    t_shift_flags();
    t_swap();
    t_bitxfer();
    t_flagop();
    t_pass();
    t_back_to_back();
    t_reset();
    report();
    $finish;
  end

endmodule